// File: doc/BRIEF.md
# Tagged memory access checker

This block guards a small internal data memory with lock-and-key tagging. Each 16-byte granule of the memory holds a 4-bit lock tag, and each request carries a 64-bit pointer whose top byte holds a 4-bit key. A load or store is allowed only when the key equals the lock of the addressed granule. The top byte never takes part in forming the memory index, so pointers with different keys reach the same location.

Besides loads and stores, the block serves tag maintenance requests. A tag read returns the lock of a granule. A tag write sets the lock and leaves the data alone. A zeroing tag write sets the lock and clears the data. A paired tag write sets the locks of two adjacent granules. Tag writes take the new lock from the key field of the request pointer.

A key/lock mismatch is reported in one of two ways, chosen per request. In precise mode it is a one-cycle fault carrying the offending pointer, and the access is suppressed. In accumulated mode the access completes and a sticky status flag records the first offending pointer. A privilege-raise strobe, when enabled, copies that status into a snapshot register.

Top module: `tag_check_unit`

## Requirements
- R1: After reset every lock tag is 0, every data word is 0, and all outputs are 0.
- R2: The key is pointer bits 59:56. The data word index is pointer bits 3 and up, and the granule index is bits 4 and up, each as wide as the memory needs. Bits 63:56 and the unused high address bits never change which location is reached.
- R3: A tag write (op code 3) sets the addressed granule's lock to the pointer key and leaves its data unchanged.
- R4: A zeroing tag write (op code 4) sets the lock to the pointer key and clears both 8-byte words of the granule.
- R5: A paired tag write (op code 5) sets the locks of granule g and granule (g+1) modulo the granule count to the pointer key.
- R6: A tag read (op code 2) returns the lock in response data bits 3:0 with all other bits 0, and never faults.
- R7: A load (op code 0) or store (op code 1) whose key equals the lock returns the stored word or writes the store data.
- R8: With precise_i high, a mismatching access raises fault_o for one cycle with fault_addr_o equal to the full pointer. A faulting store leaves memory unchanged, and a faulting load returns 0.
- R9: With precise_i low, a mismatching access completes normally without fault_o. It sets async_flag_o, which stays set, and async_addr_o keeps the first mismatching pointer while the flag is set.
- R10: async_clr_i clears the flag and address. A mismatch in the same cycle wins and records the new pointer.
- R11: When priv_raise_i and snap_en_i are both high, the snapshot outputs take the status values from before that cycle. Otherwise the snapshot outputs hold their values.
- R12: Granules with index at or above UNTAG_FROM are untagged. Accesses there are never checked and never fault or set the flag.
- R13: rsp_valid_o is high exactly one cycle after each cycle with req_valid_i high. The response and fault outputs belong to that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 3 | 0 load, 1 store, 2 tag read, 3 tag write, 4 zeroing tag write, 5 paired tag write |
| req_ptr_i | input | 64 | Tagged pointer: key in 59:56, byte address below |
| req_wdata_i | input | 64 | Store data |
| precise_i | input | 1 | 1: precise fault, 0: accumulated status |
| async_clr_i | input | 1 | Clear accumulated status |
| priv_raise_i | input | 1 | Privilege-raise strobe |
| snap_en_i | input | 1 | Enables status snapshot on privilege raise |
| rsp_valid_o | output | 1 | Response valid |
| rsp_rdata_o | output | 64 | Load data or lock tag |
| fault_o | output | 1 | Precise mismatch fault |
| fault_addr_o | output | 64 | Faulting pointer |
| async_flag_o | output | 1 | Sticky accumulated mismatch flag |
| async_addr_o | output | 64 | First accumulated mismatching pointer |
| snap_flag_o | output | 1 | Snapshot of flag |
| snap_addr_o | output | 64 | Snapshot of address |

## Verification
Every result of a request appears at the edge after the request is sampled. That covers response data, the fault and its address, the status flag and address, and the snapshot. Memory and lock updates are visible to a request issued in the next cycle. The bench drives each request on a falling edge and computes the expected outputs and next model state from its own behavioural arrays. It compares all outputs on the following falling edge, which is exactly one register stage later. Effects on memory or locks are observed through later loads and tag reads.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_STORE   = 3'd1,
    OP_TAG_RD  = 3'd2,
    OP_TAG_WR  = 3'd3,
    OP_TAG_WRZ = 3'd4,
    OP_TAG_WR2 = 3'd5
  } tcu_op_e;

  localparam int PTR_W   = 64;
  localparam int KEY_W   = 4;
  localparam int KEY_LSB = 56;
  localparam int WORD_B  = 8;   // bytes per data word
  localparam int GRAN_B  = 16;  // bytes per granule
  localparam int WPG     = GRAN_B / WORD_B;
endpackage

// File: rtl/tcu_tag_store.sv
module tcu_tag_store #(
  parameter int NUM_GRAN   = 16,
  parameter int UNTAG_FROM = 12,
  parameter int TAG_W      = 4,
  localparam int GIDX_W    = $clog2(NUM_GRAN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GIDX_W-1:0] gidx_i,
  input  logic [TAG_W-1:0]  key_i,
  input  logic              set_i,
  input  logic              set_pair_i,
  output logic [TAG_W-1:0]  lock_o,
  output logic              pass_o
);
  logic [TAG_W-1:0]  tag_q [NUM_GRAN];
  logic [GIDX_W-1:0] gidx_nxt;
  logic              untagged;

  assign gidx_nxt = gidx_i + 1'b1;  // wraps: NUM_GRAN is a power of two
  assign untagged = int'(gidx_i) >= UNTAG_FROM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < NUM_GRAN; g++) tag_q[g] <= '0;
    end else begin
      for (int g = 0; g < NUM_GRAN; g++) begin
        if ((set_i && int'(gidx_i) == g) || (set_pair_i && int'(gidx_nxt) == g))
          tag_q[g] <= key_i;
      end
    end
  end

  assign lock_o = tag_q[gidx_i];
  assign pass_o = untagged || (tag_q[gidx_i] == key_i);

  a_r5_pair_sets_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_pair_i |=> tag_q[$past(gidx_nxt)] == $past(key_i));
  a_r3_set_takes_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> tag_q[$past(gidx_i)] == $past(key_i));
endmodule

// File: rtl/tcu_data_store.sv
module tcu_data_store #(
  parameter int NUM_WORDS = 32,
  parameter int DATA_W    = 64,
  parameter int WPG       = 2,
  localparam int WIDX_W   = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDX_W-1:0] widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              zero_gran_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [NUM_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NUM_WORDS; w++) mem_q[w] <= '0;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (zero_gran_i && (int'(widx_i) / WPG) == (w / WPG)) mem_q[w] <= '0;
        else if (we_i && int'(widx_i) == w)                  mem_q[w] <= wdata_i;
      end
    end
  end

  assign rdata_o = mem_q[widx_i];

  a_r4_zero_clears_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_gran_i |=> mem_q[$past(widx_i)] == '0);
  a_r7_store_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !zero_gran_i) |=> mem_q[$past(widx_i)] == $past(wdata_i));
endmodule

// File: rtl/tcu_async_status.sv
module tcu_async_status #(
  parameter int ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mismatch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clr_i,
  input  logic              raise_i,
  input  logic              snap_en_i,
  output logic              flag_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              snap_flag_o,
  output logic [ADDR_W-1:0] snap_addr_o
);
  logic              flag_q, snap_flag_q;
  logic [ADDR_W-1:0] addr_q, snap_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      addr_q <= '0;
    end else if (mismatch_i) begin
      flag_q <= 1'b1;
      if (!flag_q || clr_i) addr_q <= addr_i;  // keep first record
    end else if (clr_i) begin
      flag_q <= 1'b0;
      addr_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_flag_q <= 1'b0;
      snap_addr_q <= '0;
    end else if (raise_i && snap_en_i) begin
      snap_flag_q <= flag_q;
      snap_addr_q <= addr_q;
    end
  end

  assign flag_o      = flag_q;
  assign addr_o      = addr_q;
  assign snap_flag_o = snap_flag_q;
  assign snap_addr_o = snap_addr_q;

  a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  a_r9_first_addr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> $stable(addr_q));
  a_r10_clear_wins_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !mismatch_i) |=> !flag_q);
  a_r11_snap_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(raise_i && snap_en_i) |=> ($stable(snap_flag_q) && $stable(snap_addr_q)));
endmodule

// File: rtl/tag_check_unit.sv
module tag_check_unit
  import tcu_pkg::*;
#(
  parameter int NUM_GRAN   = 16,
  parameter int UNTAG_FROM = 12,
  localparam int NUM_WORDS = NUM_GRAN * WPG,
  localparam int GIDX_W    = $clog2(NUM_GRAN),
  localparam int WIDX_W    = $clog2(NUM_WORDS),
  localparam int GRAN_LSB  = $clog2(GRAN_B),
  localparam int WORD_LSB  = $clog2(WORD_B)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [2:0]       req_op_i,
  input  logic [PTR_W-1:0] req_ptr_i,
  input  logic [PTR_W-1:0] req_wdata_i,
  input  logic             precise_i,
  input  logic             async_clr_i,
  input  logic             priv_raise_i,
  input  logic             snap_en_i,
  output logic             rsp_valid_o,
  output logic [PTR_W-1:0] rsp_rdata_o,
  output logic             fault_o,
  output logic [PTR_W-1:0] fault_addr_o,
  output logic             async_flag_o,
  output logic [PTR_W-1:0] async_addr_o,
  output logic             snap_flag_o,
  output logic [PTR_W-1:0] snap_addr_o
);
  tcu_op_e           op;
  logic [GIDX_W-1:0] gidx;
  logic [WIDX_W-1:0] widx;
  logic [KEY_W-1:0]  key, lock;
  logic              pass, is_access, mismatch, sync_fault, async_mis;
  logic              tag_set, tag_pair, tag_zero, store_we;
  logic [PTR_W-1:0]  mem_rdata, rdata_d;

  assign op   = tcu_op_e'(req_op_i);
  assign gidx = req_ptr_i[GRAN_LSB +: GIDX_W];
  assign widx = req_ptr_i[WORD_LSB +: WIDX_W];
  assign key  = req_ptr_i[KEY_LSB +: KEY_W];

  assign is_access  = req_valid_i && (op == OP_LOAD || op == OP_STORE);
  assign mismatch   = is_access && !pass;
  assign sync_fault = mismatch && precise_i;
  assign async_mis  = mismatch && !precise_i;

  assign tag_set  = req_valid_i && (op == OP_TAG_WR || op == OP_TAG_WRZ || op == OP_TAG_WR2);
  assign tag_pair = req_valid_i && (op == OP_TAG_WR2);
  assign tag_zero = req_valid_i && (op == OP_TAG_WRZ);
  assign store_we = req_valid_i && (op == OP_STORE) && !sync_fault;

  tcu_tag_store #(
    .NUM_GRAN  (NUM_GRAN),
    .UNTAG_FROM(UNTAG_FROM),
    .TAG_W     (KEY_W)
  ) u_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gidx_i    (gidx),
    .key_i     (key),
    .set_i     (tag_set),
    .set_pair_i(tag_pair),
    .lock_o    (lock),
    .pass_o    (pass)
  );

  tcu_data_store #(
    .NUM_WORDS(NUM_WORDS),
    .DATA_W   (PTR_W),
    .WPG      (WPG)
  ) u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .widx_i     (widx),
    .wdata_i    (req_wdata_i),
    .we_i       (store_we),
    .zero_gran_i(tag_zero),
    .rdata_o    (mem_rdata)
  );

  tcu_async_status #(.ADDR_W(PTR_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mismatch_i (async_mis),
    .addr_i     (req_ptr_i),
    .clr_i      (async_clr_i),
    .raise_i    (priv_raise_i),
    .snap_en_i  (snap_en_i),
    .flag_o     (async_flag_o),
    .addr_o     (async_addr_o),
    .snap_flag_o(snap_flag_o),
    .snap_addr_o(snap_addr_o)
  );

  always_comb begin
    rdata_d = '0;
    if (req_valid_i) begin
      unique case (op)
        OP_LOAD:   rdata_d = sync_fault ? '0 : mem_rdata;
        OP_TAG_RD: rdata_d = PTR_W'(lock);
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_rdata_o  <= '0;
      fault_o      <= 1'b0;
      fault_addr_o <= '0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      rsp_rdata_o  <= rdata_d;
      fault_o      <= sync_fault;
      fault_addr_o <= sync_fault ? req_ptr_i : '0;
    end
  end

  a_r13_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r13_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r8_fault_only_precise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($past(precise_i) && $past(req_valid_i)));
  a_r8_fault_carries_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> fault_addr_o == $past(req_ptr_i));
  a_r12_untagged_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && int'(gidx) >= UNTAG_FROM) |=> !fault_o);
  a_r6_tag_read_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op == OP_TAG_RD) |=> (!fault_o && rsp_rdata_o[PTR_W-1:KEY_W] == '0));
endmodule

// File: tb/tb_tag_check_unit.sv
module tb_tag_check_unit;
  localparam int NG = 16;
  localparam int NW = 32;
  localparam int UF = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [63:0] req_ptr = '0, req_wdata = '0;
  logic        precise = 1'b0, clr = 1'b0, raise = 1'b0, snap_en = 1'b0;
  logic        rsp_valid, fault, aflag, sflag;
  logic [63:0] rdata, faddr, aaddr, saddr;

  int errors = 0, checks = 0;
  bit done = 0;

  // behavioural model
  int          m_tag [NG];
  logic [63:0] m_mem [NW];
  bit          m_flag = 0, m_sflag = 0;
  logic [63:0] m_addr = '0, m_saddr = '0;

  always #2 clk = ~clk;

  tag_check_unit #(.NUM_GRAN(NG), .UNTAG_FROM(UF)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_ptr_i(req_ptr), .req_wdata_i(req_wdata), .precise_i(precise),
    .async_clr_i(clr), .priv_raise_i(raise), .snap_en_i(snap_en),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rdata), .fault_o(fault),
    .fault_addr_o(faddr), .async_flag_o(aflag), .async_addr_o(aaddr),
    .snap_flag_o(sflag), .snap_addr_o(saddr));

  function automatic logic [63:0] mk(input logic [3:0] key, input logic [55:0] a);
    return {4'hA, key, a};  // junk in 63:60 must be ignored
  endfunction

  task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [2:0] op, input logic [63:0] p,
                      input logic [63:0] wd, input string req);
    int g, w, k;
    bit mis;
    logic [63:0] e_rd = '0, e_fa = '0;
    bit e_f = 0;
    g = int'(p[7:4]); w = int'(p[7:3]); k = int'(p[59:56]);
    req_valid = v; req_op = op; req_ptr = p; req_wdata = wd;
    mis = v && (op == 0 || op == 1) && (g < UF) && (m_tag[g] != k);
    if (raise && snap_en) begin m_sflag = m_flag; m_saddr = m_addr; end
    if (v) begin
      case (op)
        3'd0: if (mis && precise) begin e_f = 1; e_fa = p; end else e_rd = m_mem[w];
        3'd1: if (mis && precise) begin e_f = 1; e_fa = p; end else m_mem[w] = wd;
        3'd2: e_rd = 64'(m_tag[g]);
        3'd3: m_tag[g] = k;
        3'd4: begin m_tag[g] = k; m_mem[(w/2)*2] = '0; m_mem[(w/2)*2+1] = '0; end
        3'd5: begin m_tag[g] = k; m_tag[(g+1)%NG] = k; end
        default: ;
      endcase
    end
    if (mis && !precise) begin
      if (!m_flag || clr) m_addr = p;
      m_flag = 1;
    end else if (clr) begin m_flag = 0; m_addr = '0; end
    @(negedge clk);
    cmp({req, " rsp_valid"}, 64'(rsp_valid), 64'(v));
    cmp({req, " rdata"}, rdata, e_rd);
    cmp({req, " fault"}, {63'b0, fault}, {63'b0, e_f});
    cmp({req, " fault_addr"}, faddr, e_fa);
    cmp({req, " async_flag"}, {63'b0, aflag}, {63'b0, m_flag});
    cmp({req, " async_addr"}, aaddr, m_addr);
    cmp({req, " snap_flag"}, {63'b0, sflag}, {63'b0, m_sflag});
    cmp({req, " snap_addr"}, saddr, m_saddr);
    req_valid = 0; clr = 0; raise = 0; snap_en = 0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NG; i++) m_tag[i] = 0;
    for (int i = 0; i < NW; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    cmp("R1 rsp_valid", 64'(rsp_valid), 0);
    cmp("R1 rdata", rdata, 0);
    cmp("R1 fault", 64'(fault), 0);
    cmp("R1 async_flag", 64'(aflag), 0);
    cmp("R1 snap", {63'b0, sflag} | saddr, 0);
    step(1, 3'd0, mk(0, 56'h00), 0, "R1 load reset mem");
    step(1, 3'd2, mk(0, 56'h70), 0, "R1 tag read reset");
    // R7 matching access
    precise = 1;
    step(1, 3'd1, mk(0, 56'h00), 64'hDEAD_BEEF_0000_0001, "R7 store match");
    step(1, 3'd0, mk(0, 56'h00), 0, "R7 load match");
    step(1, 3'd1, mk(0, 56'h18), 64'h1111_2222_3333_4444, "R7 store word1");
    // R3 tag write keeps data, R6 tag read
    step(1, 3'd3, mk(5, 56'h10), 0, "R3 tag write");
    step(1, 3'd2, mk(0, 56'h18), 0, "R6 tag read");
    step(1, 3'd0, mk(5, 56'h18), 0, "R3 data kept");
    // R8 precise faults
    step(1, 3'd1, mk(3, 56'h18), 64'hBAD, "R8 store mismatch");
    step(1, 3'd0, mk(5, 56'h18), 0, "R8 store suppressed");
    step(1, 3'd0, mk(7, 56'h10), 0, "R8 load mismatch");
    step(0, 3'd0, 0, 0, "R13 idle");
    // R4 zeroing tag write
    step(1, 3'd4, mk(9, 56'h18), 0, "R4 tag write zero");
    step(1, 3'd0, mk(9, 56'h10), 0, "R4 word0 zero");
    step(1, 3'd0, mk(9, 56'h18), 0, "R4 word1 zero");
    // R5 paired writes, including wrap
    step(1, 3'd5, mk(4'hC, 56'h20), 0, "R5 pair write");
    step(1, 3'd2, mk(0, 56'h20), 0, "R5 tag g");
    step(1, 3'd2, mk(0, 56'h30), 0, "R5 tag g+1");
    step(1, 3'd2, mk(0, 56'h40), 0, "R5 tag g+2 untouched");
    step(1, 3'd5, mk(4'h6, 56'hF0), 0, "R5 pair wrap");
    step(1, 3'd2, mk(0, 56'h00), 0, "R5 wrap tag g0");
    // R2 key field and ignored high bits reach same word
    step(1, 3'd1, mk(6, 56'h00) | (64'h1 << 40), 64'h55AA, "R2 store high bits");
    step(1, 3'd0, mk(6, 56'h00), 0, "R2 load alias");
    // R9 accumulated mode
    precise = 0;
    step(1, 3'd0, mk(1, 56'h20), 0, "R9 load mismatch async");
    step(1, 3'd1, mk(2, 56'h28), 64'h77, "R9 store mismatch async");
    step(1, 3'd0, mk(4'hC, 56'h28), 0, "R9 store performed");
    // R11 snapshot
    raise = 1; snap_en = 0;
    step(0, 3'd0, 0, 0, "R11 raise no enable");
    raise = 1; snap_en = 1;
    step(0, 3'd0, 0, 0, "R11 raise enabled");
    // R10 clear
    clr = 1;
    step(0, 3'd0, 0, 0, "R10 clear");
    step(1, 3'd0, mk(3, 56'h30), 0, "R10 new record");
    clr = 1;
    step(1, 3'd0, mk(8, 56'h20), 0, "R10 clear with mismatch");
    raise = 1; snap_en = 1;
    step(0, 3'd0, 0, 0, "R11 second snapshot");
    // R12 untagged region
    precise = 1;
    step(1, 3'd1, mk(6, 56'hC0), 64'h99, "R12 untagged store");
    step(1, 3'd0, mk(2, 56'hC0), 0, "R12 untagged load");
    precise = 0;
    step(1, 3'd0, mk(4'hF, 56'hD8), 0, "R12 untagged async");
    step(0, 3'd0, 0, 0, "R13 idle end");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule